// File: doc/BRIEF.md
# Four-Way Write-Through Cache Controller

This block controls a 32 KB set-associative data cache with four ways and 64-byte lines, serving a single processor port. It keeps the tag and valid arrays, the line storage, and a comparator that checks all four ways of the selected set in the same cycle. A sequencing state machine then handles each load or store to completion. The processor port transfers one 32-bit word per access. The memory side uses a request/acknowledge handshake that returns a whole line on a fetch and accepts a single word on a write-through.

Stores are written through and do not allocate on a miss. A store that hits updates the cached word and also writes it to memory. A store that misses goes to memory only. A load miss fetches the line, installs it in the way named by an external replacement unit, and returns the requested word in the same step. Two event counters record hits and misses, one event per processor access.

Top module: `cache_ctrl_wt`

## Requirements
- R1: A byte address splits into tag = bits 31:13, set = bits 12:6 and offset = bits 5:0. The word within a line is offset bits 5:2, and word i of a line sits at bits 32*i+31 down to 32*i of the 512-bit line bus.
- R2: A way hits only when its valid bit is set and its stored tag equals the request tag. At most one way hits. After reset every access misses, whatever tag it carries.
- R3: A read hit returns the cached word with `cpu_ready` high in the cycle after the strobe is seen, and it makes no memory request.
- R4: A read miss makes one line request with `mem_we` low and `mem_addr` equal to the request address with bits 5:0 cleared. On acknowledge, the line is installed in the way given on `victim_way` during the return cycle, and the requested word is returned. A later read of any word of that line hits.
- R5: A write hit updates the word in the cache and makes one memory write (`mem_we` high) with `mem_addr` equal to the processor address and `mem_wdata` equal to the store data. `cpu_ready` follows the acknowledge.
- R6: A write miss makes the same single memory write and allocates nothing, so a following read of that address misses.
- R7: `hit_count` and `miss_count` each grow by exactly one per access that hits or misses, respectively.
- R8: A synchronous active-high `rst` clears both counters and every valid bit. `cpu_ready` and `mem_req` are low while reset is held and right after it.
- R9: `cpu_ready` is high for exactly one cycle per access. Strobes are held until ready. If `cpu_rd` and `cpu_wr` are both high, the read is served and no store takes place.
- R10: `mem_req` stays high from the start of a memory transfer through the cycle with `mem_ack`, and drops in the next cycle.
- R11: Installing a line into a way evicts whatever that way held for the set, so the evicted line misses afterwards while lines in the other ways still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 32 | Processor byte address |
| cpu_rd | input | 1 | Load strobe, held until ready |
| cpu_wr | input | 1 | Store strobe, held until ready |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | High for a word write, low for a line fetch |
| mem_addr | output | 32 | Line address (fetch) or word address (write) |
| mem_wdata | output | 32 | Write-through data |
| mem_rline | input | 512 | Fetched line, sampled with mem_ack |
| mem_ack | input | 1 | Memory completion, one cycle |
| victim_way | input | 2 | Way that receives a fetched line |
| hit_count | output | 32 | Accesses that hit |
| miss_count | output | 32 | Accesses that missed |

## Verification
The bench aims first at allocation on stores. A design that allocated on a write miss would turn the following read into a hit with no line fetch. A design that skipped the cache update on a write hit would return stale data on the next read hit. It also reads after reset with a zero tag, which catches a comparator that ignores the valid bit. It fills all four ways of one set and then replaces one of them, which exposes a fill into the wrong way or a fill into every way. Finally it raises both strobes together, sweeps words across one line to expose a wrong word slice, and checks the counters after every access to catch double counting on the multi-cycle miss paths.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

    // Controller sequencing states; IDLE must encode as zero (reset value).
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_READ  = 4'd1,
        ST_RMISS = 4'd2,
        ST_RMEM  = 4'd3,
        ST_RDATA = 4'd4,
        ST_WRITE = 4'd5,
        ST_WHIT  = 4'd6,
        ST_WMISS = 4'd7,
        ST_WMEM  = 4'd8,
        ST_WDATA = 4'd9
    } cwt_state_e;

endpackage

// File: rtl/cwt_tag_store.sv
module cwt_tag_store #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 19,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_valid,
    input  logic                        fill_en,
    input  logic [SET_W-1:0]            fill_set,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  valid_q;
        logic             sel;

        assign sel = fill_en && (fill_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
            end else if (sel) begin
                valid_q[fill_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[fill_set] <= fill_tag;
            end
        end

        assign rd_tag[w]   = tag_q[rd_set];
        assign rd_valid[w] = valid_q[rd_set];
    end

endmodule

// File: rtl/cwt_hit_cmp.sv
module cwt_hit_cmp #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 19,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        chk_en,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0]             way_valid,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_idx
);

    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_idx = WAY_W'(w);
            end
        end
    end

    assign hit = |hit_vec;

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> $onehot0(hit_vec));

endmodule

// File: rtl/cwt_data_store.sv
module cwt_data_store #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WIDX_W = $clog2(LINE_W / WORD_W)
) (
    input  logic                clk,
    input  logic [SET_W-1:0]    rd_set,
    input  logic [WAY_W-1:0]    rd_way,
    input  logic [WIDX_W-1:0]   rd_word,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                fill_en,
    input  logic [SET_W-1:0]    fill_set,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic [LINE_W-1:0]   fill_line,
    input  logic                wr_en,
    input  logic [SET_W-1:0]    wr_set,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic [WIDX_W-1:0]   wr_word,
    input  logic [WORD_W-1:0]   wr_data
);

    logic [WAYS-1:0][LINE_W-1:0] way_line;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_W-1:0] line_q [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == WAY_W'(w))) begin
                line_q[fill_set] <= fill_line;
            end else if (wr_en && (wr_way == WAY_W'(w))) begin
                line_q[wr_set][wr_word*WORD_W +: WORD_W] <= wr_data;
            end
        end

        assign way_line[w] = line_q[rd_set];
    end

    assign rd_data = way_line[rd_way][rd_word*WORD_W +: WORD_W];

endmodule

// File: rtl/cache_ctrl_wt.sv
module cache_ctrl_wt
    import cwt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int WORD_W     = 32,
    parameter int CNT_W      = 32,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [WORD_W-1:0]   cpu_wdata,
    output logic [WORD_W-1:0]   cpu_rdata,
    output logic                cpu_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [LINE_W-1:0]   mem_rline,
    input  logic                mem_ack,
    input  logic [WAY_W-1:0]    victim_way,
    output logic [CNT_W-1:0]    hit_count,
    output logic [CNT_W-1:0]    miss_count
);

    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFS_W;
    localparam int WB_W   = $clog2(WORD_W / 8);
    localparam int WIDX_W = OFS_W - WB_W;

    typedef struct packed {
        cwt_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   wdata;
        logic [WAY_W-1:0]    way;
        logic [LINE_W-1:0]   line;
        logic [CNT_W-1:0]    hits;
        logic [CNT_W-1:0]    misses;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [SET_W-1:0]               req_set;
    logic [TAG_W-1:0]               req_tag;
    logic [WIDX_W-1:0]              req_widx;
    logic [WAYS-1:0][TAG_W-1:0]     way_tag;
    logic [WAYS-1:0]                way_valid;
    logic                           lookup_en;
    logic                           hit;
    logic [WAY_W-1:0]               hit_idx;
    logic [WORD_W-1:0]              store_word;
    logic                           fill_en;
    logic                           wr_en;

    assign req_set   = c_q.addr[OFS_W +: SET_W];
    assign req_tag   = c_q.addr[ADDR_W-1 -: TAG_W];
    assign req_widx  = c_q.addr[WB_W +: WIDX_W];
    assign lookup_en = (c_q.st == ST_READ) || (c_q.st == ST_WRITE);

    cwt_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (req_set),
        .rd_tag   (way_tag),
        .rd_valid (way_valid),
        .fill_en  (fill_en),
        .fill_set (req_set),
        .fill_way (victim_way),
        .fill_tag (req_tag)
    );

    cwt_hit_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) cmp_i (
        .clk       (clk),
        .rst       (rst),
        .chk_en    (lookup_en),
        .way_tag   (way_tag),
        .way_valid (way_valid),
        .req_tag   (req_tag),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    cwt_data_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .WORD_W(WORD_W)) data_i (
        .clk       (clk),
        .rd_set    (req_set),
        .rd_way    (hit_idx),
        .rd_word   (req_widx),
        .rd_data   (store_word),
        .fill_en   (fill_en),
        .fill_set  (req_set),
        .fill_way  (victim_way),
        .fill_line (c_q.line),
        .wr_en     (wr_en),
        .wr_set    (req_set),
        .wr_way    (c_q.way),
        .wr_word   (req_widx),
        .wr_data   (c_q.wdata)
    );

    // Next-state and output decode.
    always_comb begin
        c_d       = c_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_en   = 1'b0;
        wr_en     = 1'b0;
        cpu_rdata = store_word;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_rd) begin
                    c_d.addr = cpu_addr;
                    c_d.st   = ST_READ;
                end else if (cpu_wr) begin
                    c_d.addr  = cpu_addr;
                    c_d.wdata = cpu_wdata;
                    c_d.st    = ST_WRITE;
                end
            end
            ST_READ: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    c_d.hits  = c_q.hits + CNT_W'(1);
                    c_d.st    = ST_IDLE;
                end else begin
                    c_d.misses = c_q.misses + CNT_W'(1);
                    c_d.st     = ST_RMISS;
                end
            end
            ST_RMISS: c_d.st = ST_RMEM;
            ST_RMEM: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    c_d.line = mem_rline;
                    c_d.st   = ST_RDATA;
                end
            end
            ST_RDATA: begin
                fill_en   = 1'b1;
                cpu_ready = 1'b1;
                cpu_rdata = c_q.line[req_widx*WORD_W +: WORD_W];
                c_d.st    = ST_IDLE;
            end
            ST_WRITE: begin
                if (hit) begin
                    c_d.hits = c_q.hits + CNT_W'(1);
                    c_d.way  = hit_idx;
                    c_d.st   = ST_WHIT;
                end else begin
                    c_d.misses = c_q.misses + CNT_W'(1);
                    c_d.st     = ST_WMISS;
                end
            end
            ST_WHIT: begin
                wr_en  = 1'b1;
                c_d.st = ST_WMEM;
            end
            ST_WMISS: c_d.st = ST_WMEM;
            ST_WMEM: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    c_d.st = ST_WDATA;
                end
            end
            ST_WDATA: begin
                cpu_ready = 1'b1;
                c_d.st    = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_addr   = mem_we ? c_q.addr
                               : {c_q.addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign mem_wdata  = c_q.wdata;
    assign hit_count  = c_q.hits;
    assign miss_count = c_q.misses;

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R10
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((hit_count - $past(hit_count)) + (miss_count - $past(miss_count))) <= CNT_W'(1));

    // R6
    wmiss_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !cpu_ready);

endmodule

// File: tb/cache_ctrl_wt_tb_top.sv
module cache_ctrl_wt_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [31:0]  cpu_addr = '0;
    logic         cpu_rd = 1'b0;
    logic         cpu_wr = 1'b0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic [511:0] mem_rline = '0;
    logic         mem_ack = 1'b0;
    logic [1:0]   victim_way = '0;
    logic [31:0]  hit_count;
    logic [31:0]  miss_count;

    always #5 clk = ~clk;

    cache_ctrl_wt dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rline(mem_rline), .mem_ack(mem_ack), .victim_way(victim_way),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Memory model state
    logic [31:0] memw [logic [31:0]];
    int          rd_txn = 0;
    int          wr_txn = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    int          lat_cnt = 0;
    int          lat_cfg = 2;

    // Reference cache state
    bit          ref_valid [128][4];
    logic [18:0] ref_tag   [128][4];
    int          exp_hits = 0;
    int          exp_miss = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        logic [31:0] wa;
        wa = a & ~32'h3;
        if (memw.exists(wa)) return memw[wa];
        return (wa * 32'h9E3779B1) ^ 32'h13572468;
    endfunction

    function automatic bit ref_hit(input logic [31:0] a);
        for (int w = 0; w < 4; w++) begin
            if (ref_valid[a[12:6]][w] && ref_tag[a[12:6]][w] == a[31:13]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] mk_addr(input logic [18:0] t, input logic [6:0] s,
                                            input logic [3:0] w);
        return {t, s, w, 2'b00};
    endfunction

    // Memory responder
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (mem_req) begin
            lat_cnt++;
            if (lat_cnt >= lat_cfg) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    memw[mem_addr & ~32'h3] = mem_wdata;
                    wr_txn++;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                end else begin
                    rd_txn++;
                    last_rd_addr = mem_addr;
                    for (int i = 0; i < 16; i++)
                        mem_rline[i*32 +: 32] = mem_val(mem_addr + 32'(i * 4));
                end
                lat_cfg = 1 + int'($urandom % 4);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R8", "ready during reset", 32'(cpu_ready), 0);
        chk(mem_req == 1'b0, "R8", "mem_req during reset", 32'(mem_req), 0);
        rst = 1'b0;
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 4; w++) ref_valid[s][w] = 1'b0;
        exp_hits = 0;
        exp_miss = 0;
        @(negedge clk);
        chk(hit_count == 0 && miss_count == 0, "R8", "counters after reset",
            hit_count + miss_count, 0);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R8", "idle outputs after reset",
            {30'd0, cpu_ready, mem_req}, 0);
    endtask

    task automatic do_read(input logic [31:0] a, input logic [1:0] vw,
                           input bit both, input string rq);
        int rd0, wr0, cyc;
        bit exp_hit, ok;
        logic [31:0] got, exp_d;
        rd0 = rd_txn; wr0 = wr_txn; cyc = 0; ok = 1'b0; got = '0;
        exp_hit = ref_hit(a);
        exp_d = mem_val(a);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = both; cpu_wdata = $urandom; victim_way = vw;
        while (cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (cpu_ready) begin
                got = cpu_rdata;
                ok = 1'b1;
                break;
            end
        end
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        if (!ok) begin
            chk(1'b0, "R9", "read never completed", 0, 1);
            return;
        end
        chk(got == exp_d, rq, "read data", got, exp_d);
        if (exp_hit) begin
            exp_hits++;
            chk(cyc == 1, "R3", "hit latency", 32'(cyc), 1);
            chk(rd_txn == rd0, "R3", "no fetch on hit", 32'(rd_txn - rd0), 0);
        end else begin
            exp_miss++;
            chk(rd_txn == rd0 + 1, "R4", "one fetch on miss", 32'(rd_txn - rd0), 1);
            chk(last_rd_addr == {a[31:6], 6'd0}, "R4", "fetch address",
                last_rd_addr, {a[31:6], 6'd0});
            ref_valid[a[12:6]][vw] = 1'b1;
            ref_tag[a[12:6]][vw]   = a[31:13];
        end
        chk(wr_txn == wr0, both ? "R9" : "R3", "no write traffic on read",
            32'(wr_txn - wr0), 0);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R9", "ready one cycle", 32'(cpu_ready), 0);
        chk(hit_count == 32'(exp_hits), "R7", "hit counter", hit_count, 32'(exp_hits));
        chk(miss_count == 32'(exp_miss), "R7", "miss counter", miss_count, 32'(exp_miss));
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        int wr0, rd0, cyc;
        bit exp_hit, ok;
        string rq;
        wr0 = wr_txn; rd0 = rd_txn; cyc = 0; ok = 1'b0;
        exp_hit = ref_hit(a);
        rq = exp_hit ? "R5" : "R6";
        cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = d; victim_way = 2'($urandom);
        while (cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (cpu_ready) begin
                ok = 1'b1;
                break;
            end
        end
        cpu_wr = 1'b0;
        if (!ok) begin
            chk(1'b0, "R9", "write never completed", 0, 1);
            return;
        end
        if (exp_hit) exp_hits++; else exp_miss++;
        chk(wr_txn == wr0 + 1, rq, "one memory write", 32'(wr_txn - wr0), 1);
        chk(rd_txn == rd0, rq, "no fetch on write", 32'(rd_txn - rd0), 0);
        chk(last_wr_addr == a, rq, "write address", last_wr_addr, a);
        chk(last_wr_data == d, rq, "write data", last_wr_data, d);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R9", "write ready one cycle", 32'(cpu_ready), 0);
        chk(hit_count == 32'(exp_hits), "R7", "hit counter", hit_count, 32'(exp_hits));
        chk(miss_count == 32'(exp_miss), "R7", "miss counter", miss_count, 32'(exp_miss));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [18:0] tpool [5];
        logic [6:0]  spool [3];
        void'($urandom(32'd20250611));
        tpool[0] = 19'h00000; tpool[1] = 19'h01111; tpool[2] = 19'h2A5A5;
        tpool[3] = 19'h7FFFF; tpool[4] = 19'h40001;
        spool[0] = 7'd0; spool[1] = 7'd42; spool[2] = 7'd127;

        do_reset();

        // R2: tag zero at set zero must still miss while nothing is valid
        do_read(mk_addr(19'h0, 7'd0, 4'd0), 2'd3, 1'b0, "R2");

        // R6 then R4 then R3 / R5 on one address
        a = mk_addr(19'h12345, 7'd9, 4'd7);
        do_write(a, 32'hDEADBEEF);
        do_read(a, 2'd1, 1'b0, "R4");
        do_read(a, 2'd2, 1'b0, "R3");
        do_write(a, 32'hCAFEF00D);
        do_read(a, 2'd0, 1'b0, "R5");
        // R1: every word of the same line hits and returns its own value
        for (int w = 0; w < 16; w++) do_read(mk_addr(19'h12345, 7'd9, 4'(w)), 2'd0, 1'b0, "R1");

        // R11: fill all four ways of set 5, then replace way 2
        for (int w = 0; w < 4; w++) do_read(mk_addr(19'h100 + 19'(w), 7'd5, 4'd3), 2'(w), 1'b0, "R11");
        do_read(mk_addr(19'h200, 7'd5, 4'd3), 2'd2, 1'b0, "R11");
        do_read(mk_addr(19'h102, 7'd5, 4'd3), 2'd3, 1'b0, "R11");
        do_read(mk_addr(19'h101, 7'd5, 4'd3), 2'd0, 1'b0, "R11");

        // R9: both strobes, read served, store dropped
        do_read(mk_addr(19'h333, 7'd77, 4'd1), 2'd0, 1'b1, "R9");

        // R8: mid-run reset clears valid bits
        do_reset();
        do_read(a, 2'd1, 1'b0, "R8");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            a = mk_addr(tpool[$urandom % 5], spool[$urandom % 3], 4'($urandom));
            if (($urandom % 10) < 6) do_read(a, 2'($urandom), 1'b0, "R1");
            else do_write(a, $urandom);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule